// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block recovers bytes from an asynchronous serial line that carries frames made of one start bit, eight data bits and one stop bit. The line idles high. A small selector picks one of five bit rates. Each bit time is split into sixteen equal sample slots. The level of each bit is decided by a vote over the central slots of that bit. A short spike or a modest rate mismatch therefore does not corrupt the byte.

The raw line is retimed through a flop chain before it is used. A high-to-low transition seen while the receiver is idle opens a frame. If the start bit does not vote low, the frame is dropped with no report. When the stop bit has been decided, the received byte appears on the data output together with a single-cycle completion strobe. An error flag accompanies that strobe when the stop bit voted low. A busy output shows that a frame is in progress.

Top module: `uart_vote_rx`

## Requirements
- R1: A frame is a low start bit, eight data bits sent least significant first, then a stop bit. The received byte is driven on `data_out` in the cycle that `done` is high, with data bit 0 placed at `data_out[0]`.
- R2: `baud_sel` values 0, 1, 2, 3 and 4 select 9600, 19200, 38400, 57600 and 115200 baud. Let D = floor(CLK_HZ / (16 × rate)). One sample slot lasts D clocks and one bit lasts 16 slots. `done` is high on the 2 + 160·D-th clock edge after the first edge that samples the line low.
- R3: `baud_sel` values 5, 6 and 7 give exactly the timing of value 0.
- R4: Number the slots of a bit 0 to 15. Slot s of bit b is sampled at the edge that sees the line level from (16·b + s + 1)·D clocks after the frame's first low level. A bit is 1 when at least 4 of its slots 6 to 12 read 1. Up to three disagreeing samples in that window leave the bit unchanged, and four change it.
- R5: Samples in slots 0 to 5 and 13 to 15 of any bit have no effect on the received byte or on `frame_error`.
- R6: Only a falling edge of the retimed line while idle opens a frame. Falling edges during a frame do not restart it or shift its timing.
- R7: If the start bit votes 1, the receiver returns to idle on the 2 + 16·D-th edge after the first low sample, and it raises no `done`.
- R8: `done` lasts exactly one clock. `frame_error` is high only together with `done`, and only when the stop bit voted 0. The byte is still delivered in that case.
- R9: `busy` goes high on the second edge after the first low sample. It stays high until the frame ends, and it is low in the cycle that `done` is high.
- R10: While `rst_n` is low, `busy`, `done`, `frame_error` and `data_out` are all zero.
- R11: `data_out` keeps its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| baud_sel | input | 3 | Bit rate select |
| data_out | output | 8 | Last received byte |
| done | output | 1 | One-cycle strobe when a byte is delivered |
| frame_error | output | 1 | Stop bit voted low, valid with `done` |
| busy | output | 1 | Frame in progress |

## Verification
The bench builds the receiver with CLK_HZ set to 3,686,400, which makes D equal 24, 12, 6, 4 and 2 for the five rates. At the default 50 MHz a slow frame runs to tens of thousands of cycles. At this setting every rate, including the fallback codes, fits in a few thousand cycles. Because D stays at two or more, every single slot of every bit can be hit with a one-clock spike on its own. This makes the voting window edges, the out-of-window slots and the false-start path all reachable in a short run.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_phase_e;

  localparam int unsigned NUM_RATES = 5;

  // Clocks per sample slot minus one, for a 16-slot bit.
  function automatic int unsigned slot_terminal(input int unsigned clk_hz,
                                                input int unsigned baud);
    return (clk_hz / (baud * 16)) - 1;
  endfunction

endpackage

// File: rtl/uart_vote_rx_sync.sv
module uart_vote_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_async,
  output logic line,
  output logic line_fall
);

  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], rx_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign line      = chain_q[STAGES-1];
  assign line_fall = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/uart_vote_rx_rate.sv
module uart_vote_rx_rate
  import uart_vote_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned RATE0  = 9600,
  parameter int unsigned RATE1  = 19200,
  parameter int unsigned RATE2  = 38400,
  parameter int unsigned RATE3  = 57600,
  parameter int unsigned RATE4  = 115200,
  parameter int unsigned DIV_W  = 9
) (
  input  logic [2:0]       baud_sel,
  output logic [DIV_W-1:0] terminal
);

  localparam logic [DIV_W-1:0] TERM0 = DIV_W'(slot_terminal(CLK_HZ, RATE0));
  localparam logic [DIV_W-1:0] TERM1 = DIV_W'(slot_terminal(CLK_HZ, RATE1));
  localparam logic [DIV_W-1:0] TERM2 = DIV_W'(slot_terminal(CLK_HZ, RATE2));
  localparam logic [DIV_W-1:0] TERM3 = DIV_W'(slot_terminal(CLK_HZ, RATE3));
  localparam logic [DIV_W-1:0] TERM4 = DIV_W'(slot_terminal(CLK_HZ, RATE4));

  always_comb begin
    unique case (baud_sel)
      3'd1:    terminal = TERM1;
      3'd2:    terminal = TERM2;
      3'd3:    terminal = TERM3;
      3'd4:    terminal = TERM4;
      default: terminal = TERM0;
    endcase
  end

endmodule

// File: rtl/uart_vote_rx_timer.sv
module uart_vote_rx_timer #(
  parameter int unsigned DIV_W  = 9,
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  terminal,
  output logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              bit_end
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;

  assign tick    = run && (cnt_q == terminal);
  assign bit_end = tick && (slot_q == LAST_SLOT);
  assign slot    = slot_q;

  always_comb begin
    cnt_d  = cnt_q;
    slot_d = slot_q;
    if (!run) begin
      cnt_d  = '0;
      slot_d = '0;
    end else if (tick) begin
      cnt_d  = '0;
      slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/uart_vote_rx_voter.sv
module uart_vote_rx_voter #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned WIN_LO = 6,
  parameter int unsigned WIN_HI = 12,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              bit_end,
  input  logic              sample,
  output logic              vote
);

  localparam int unsigned WIN_LEN = WIN_HI - WIN_LO + 1;
  localparam int unsigned THRESH  = WIN_LEN / 2 + 1;
  localparam int unsigned CNT_W   = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0] ones_q, ones_d;
  logic             in_win;
  logic             hit;

  assign in_win = (32'(slot) >= WIN_LO) && (32'(slot) <= WIN_HI);
  assign hit    = tick && in_win && sample;
  assign vote   = (32'(ones_q) + 32'(hit)) >= THRESH;

  always_comb begin
    ones_d = ones_q;
    if (!run || bit_end) begin
      ones_d = '0;
    end else if (hit) begin
      ones_d = ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else begin
      ones_q <= ones_d;
    end
  end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uart_vote_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned RATE0     = 9600,
  parameter int unsigned RATE1     = 19200,
  parameter int unsigned RATE2     = 38400,
  parameter int unsigned RATE3     = 57600,
  parameter int unsigned RATE4     = 115200,
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned SLOTS     = 16,
  parameter int unsigned WIN_LO    = 6,
  parameter int unsigned WIN_HI    = 12,
  parameter int unsigned SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_in,
  input  logic [2:0]           baud_sel,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 done,
  output logic                 frame_error,
  output logic                 busy
);

  localparam int unsigned DIV_W  = $clog2(slot_terminal(CLK_HZ, RATE0) + 1);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned BIT_W  = $clog2(DATA_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  // Reset: asserted at once, released after two clean edges.
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  logic              line;
  logic              line_fall;
  logic [DIV_W-1:0]  terminal;
  logic              run;
  logic              tick;
  logic [SLOT_W-1:0] slot;
  logic              bit_end;
  logic              vote;

  uart_vote_rx_sync #(.STAGES(SYNC_LEN)) i_sync (
    .clk       (clk),
    .rst_n     (rst_i),
    .rx_async  (rx_in),
    .line      (line),
    .line_fall (line_fall)
  );

  uart_vote_rx_rate #(
    .CLK_HZ (CLK_HZ),
    .RATE0  (RATE0),
    .RATE1  (RATE1),
    .RATE2  (RATE2),
    .RATE3  (RATE3),
    .RATE4  (RATE4),
    .DIV_W  (DIV_W)
  ) i_rate (
    .baud_sel (baud_sel),
    .terminal (terminal)
  );

  uart_vote_rx_timer #(.DIV_W(DIV_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_i),
    .run      (run),
    .terminal (terminal),
    .tick     (tick),
    .slot     (slot),
    .bit_end  (bit_end)
  );

  uart_vote_rx_voter #(
    .SLOTS  (SLOTS),
    .WIN_LO (WIN_LO),
    .WIN_HI (WIN_HI),
    .SLOT_W (SLOT_W)
  ) i_voter (
    .clk     (clk),
    .rst_n   (rst_i),
    .run     (run),
    .tick    (tick),
    .slot    (slot),
    .bit_end (bit_end),
    .sample  (line),
    .vote    (vote)
  );

  rx_phase_e            phase_q, phase_d;
  logic [BIT_W-1:0]     bit_q, bit_d;
  logic [DATA_BITS-1:0] shift_q, shift_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 done_q, done_d;
  logic                 ferr_q, ferr_d;

  assign run = (phase_q != RX_IDLE);

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    data_d  = data_q;
    done_d  = 1'b0;
    ferr_d  = 1'b0;
    unique case (phase_q)
      RX_IDLE: begin
        if (line_fall) begin
          phase_d = RX_START;
          bit_d   = '0;
        end
      end
      RX_START: begin
        if (bit_end) begin
          phase_d = vote ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (bit_end) begin
          shift_d = {vote, shift_q[DATA_BITS-1:1]};
          bit_d   = bit_q + 1'b1;
          if (bit_q == LAST_BIT) begin
            phase_d = RX_STOP;
          end
        end
      end
      RX_STOP: begin
        if (bit_end) begin
          phase_d = RX_IDLE;
          data_d  = shift_q;
          done_d  = 1'b1;
          ferr_d  = ~vote;
        end
      end
      default: phase_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      phase_q <= RX_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      data_q  <= '0;
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      data_q  <= data_d;
      done_q  <= done_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data_out    = data_q;
  assign done        = done_q;
  assign frame_error = ferr_q;
  assign busy        = run;

endmodule

// File: rtl/uart_vote_rx_chk.sv
module uart_vote_rx_chk #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_in,
  input logic                 busy,
  input logic                 done,
  input logic                 frame_error,
  input logic [DATA_BITS-1:0] data_out
);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ferr_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> done);

  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_data_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(data_out));

  assert_start_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(rx_in, 2));

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R10: assert (!busy && !done && !frame_error);
    end
  end

endmodule

bind uart_vote_rx uart_vote_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_in       (rx_in),
  .busy        (busy),
  .done        (done),
  .frame_error (frame_error),
  .data_out    (data_out)
);

// File: tb/test_uart_vote_rx.sv
`timescale 1ns/1ps
module test_uart_vote_rx;

  localparam int unsigned CLK_HZ = 3_686_400;
  localparam int RATES [5] = '{9600, 19200, 38400, 57600, 115200};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [2:0] baud_sel = 3'd0;
  logic [7:0] data_out;
  logic       done;
  logic       frame_error;
  logic       busy;

  uart_vote_rx #(.CLK_HZ(CLK_HZ)) i_uart_vote_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_in       (rx),
    .baud_sel    (baud_sel),
    .data_out    (data_out),
    .done        (done),
    .frame_error (frame_error),
    .busy        (busy)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         start;
    int         stop_at;
    bit         has_done;
    logic [7:0] data;
    bit         ferr;
    string      tag;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] exp_data = 8'h00;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;
  bit         cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
               req, what, cyc, act, expv);
    end
  endtask

  function automatic int div_of(input int sel);
    int s;
    s = (sel > 4) ? 0 : sel;
    return CLK_HZ / (16 * RATES[s]);
  endfunction

  function automatic bit vote_of(input bit lvl, input logic [159:0] fl, input int b);
    int ones;
    ones = 0;
    for (int s = 6; s <= 12; s++) ones += int'(lvl ^ fl[16*b + s]);
    return ones >= 4;
  endfunction

  function automatic logic [159:0] slots(input int lo, input int hi,
                                         input int blo, input int bhi);
    logic [159:0] m;
    m = '0;
    for (int b = blo; b <= bhi; b++)
      for (int s = lo; s <= hi; s++) m[16*b + s] = 1'b1;
    return m;
  endfunction

  // Reference model compared on every clock, sampled at the falling edge.
  always @(negedge clk) begin
    logic e_busy, e_done, e_ferr;
    string tg;
    if (cmp_on) begin
      e_busy = 1'b0; e_done = 1'b0; e_ferr = 1'b0; tg = "R1";
      if (expq.size() > 0) begin
        tg = expq[0].tag;
        if (cyc >= expq[0].start && cyc < expq[0].stop_at) e_busy = 1'b1;
        if (cyc == expq[0].stop_at && expq[0].has_done) begin
          e_done   = 1'b1;
          e_ferr   = expq[0].ferr;
          exp_data = expq[0].data;
        end
      end
      chk(busy == e_busy, "R9", {"busy ", tg}, busy, e_busy);
      chk(done == e_done, "R2", {"done timing ", tg}, done, e_done);
      chk(frame_error == e_ferr, "R8", {"frame_error ", tg}, frame_error, e_ferr);
      chk(data_out == exp_data, (e_done ? tg : "R11"), "data_out", data_out, exp_data);
      if (expq.size() > 0 && cyc >= expq[0].stop_at) void'(expq.pop_front());
    end
  end

  task automatic send_frame(input int sel, input logic [7:0] d, input bit stop,
                            input logic [159:0] fl, input bit fstart, input string tag);
    int         dv, len, k, b, j;
    logic [9:0] lv;
    logic       v;
    exp_t       e;
    dv = div_of(sel);
    lv = {stop, d, 1'b0};
    @(negedge clk);
    baud_sel = 3'(sel);
    repeat (3) @(negedge clk);
    len = fstart ? (16*dv + 4) : (161*dv + 4);
    for (int o = 0; o < len; o++) begin
      @(negedge clk);
      if (o == 0) begin
        k = cyc + 1;
        e.start    = k + 2;
        e.has_done = !fstart;
        e.stop_at  = fstart ? (k + 2 + 16*dv) : (k + 2 + 160*dv);
        for (int i = 0; i < 8; i++) e.data[i] = vote_of(d[i], fl, i + 1);
        e.ferr = !vote_of(stop, fl, 9);
        e.tag  = tag;
        expq.push_back(e);
      end
      b = o / (16*dv);
      v = (b >= 10) ? 1'b1 : lv[b];
      if (fstart && o >= 3*dv) v = 1'b1;
      if (o > 0 && (o % dv) == 0) begin
        j = o / dv - 1;
        if (j < 160 && fl[j]) v = ~v;
      end
      rx = v;
    end
    @(negedge clk);
    rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: outputs held at zero during reset
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(frame_error == 1'b0, "R10", "frame_error in reset", frame_error, 0);
    chk(data_out == 8'h00, "R10", "data_out in reset", data_out, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    repeat (10) @(negedge clk);

    send_frame(4, 8'hA5, 1'b1, '0, 1'b0, "R1");
    send_frame(0, 8'h3C, 1'b1, '0, 1'b0, "R2");
    send_frame(7, 8'h81, 1'b1, '0, 1'b0, "R3");
    send_frame(5, 8'h7E, 1'b1, '0, 1'b0, "R3");
    send_frame(2, 8'h5A, 1'b1,
               slots(6, 6, 0, 9) | slots(9, 9, 0, 9) | slots(12, 12, 0, 9),
               1'b0, "R4");
    send_frame(4, 8'hFF, 1'b1, slots(6, 9, 1, 1) | slots(10, 12, 8, 8), 1'b0, "R4");
    send_frame(1, 8'hC3, 1'b1, slots(0, 5, 0, 9) | slots(13, 15, 0, 9), 1'b0, "R5");
    send_frame(3, 8'h96, 1'b1, slots(0, 0, 1, 9) | slots(15, 15, 0, 8), 1'b0, "R6");
    send_frame(4, 8'h12, 1'b0, '0, 1'b1, "R7");
    send_frame(4, 8'h6D, 1'b1, '0, 1'b0, "R7");
    send_frame(3, 8'h00, 1'b0, '0, 1'b0, "R8");
    send_frame(2, 8'hE7, 1'b1, slots(6, 9, 9, 9), 1'b0, "R8");
    send_frame(2, 8'h24, 1'b0, slots(7, 9, 9, 9), 1'b0, "R8");
    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule